// File: doc/BRIEF.md
# Idle Wake Interval Timer

This block is a hidden interval counter that advances once per instruction cycle. It marks a fixed period for an idle controller. Software cannot read, load, start or halt the counter, and the counter has no reset. Its phase is therefore arbitrary.

A small select register picks one of five power-of-two counter taps. Each time the chosen tap bit changes state, the block does two things. It emits a one-clock wake pulse, and it sets a sticky pending flag. The flag drives the interrupt output only while the enable bit is set. Software clears the flag by writing zero to it.

The register port has one address bit. Address 0 holds the tap select. Address 1 holds the enable and pending bits. Reads are combinational on the same address.

Top module: `idle_wake_timer`

## Requirements
- R1: Select codes 0, 1, 2, 3 and 4 give a wake period of 2^(TAP_LSB+code) strobe cycles. At the default TAP_LSB of 12 these are 4096, 8192, 16384, 32768 and 65536 cycles.
- R2: After reset:
  - the select register, the enable, the pending flag, `irq_o` and `wake_o` are all 0;
  - with the strobe held high, the first wake arrives 1 to 2^TAP_LSB cycles after reset is released.
- R3: Select codes 5, 6 and 7 give the same period as code 4.
- R4: The counter advances only in cycles where `cyc_en` is high, so the period is counted in strobe cycles and not in clocks.
- R5: `wake_o` is high for exactly one clock. It rises at the clock edge that ends the strobe cycle in which the selected tap changes. The pending flag is set at that same edge.
- R6: `irq_o` is high exactly when both the pending flag and the enable are 1.
- R7: Writing to the pending bit works as follows:
  - writing 0 clears the flag;
  - writing 1 leaves the flag unchanged;
  - if a tap event occurs in the same cycle as a clearing write, the flag stays set.
- R8: The register layout is:
  - address 0, bits [2:0]: the tap select, read back as written;
  - address 1: bit 0 is the enable and bit 1 is the pending flag;
  - a write to address 1 never changes the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the registers (the counter has no reset) |
| cyc_en | input | 1 | Instruction-cycle strobe; the counter advances while it is high |
| reg_addr | input | 1 | Register address: 0 is the select, 1 is the control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | SEL_W | Write data |
| reg_rdata | output | SEL_W | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | One-clock wake pulse each period |

## Verification
The block registers every result once. A tap event shows on `wake_o`, on the pending flag and on `irq_o` one clock after the strobe cycle that caused it. A register write shows on `reg_rdata` one clock after the write.

All outputs are sampled on the falling edge, so each check falls half a cycle after the rising edge that produced the result. The spacing between wake pulses is measured in falling edges, and the bench compares that spacing against queued periods.

After each change of select or strobe rate, the scoreboard ignores the first wake. That wake may still belong to the old tap or to an arbitrary phase, so only the spacings after it are compared. The test of a clear write that coincides with a tap event counts 63 edges from a known wake to land the write on the cycle of the next event.

// File: rtl/idle_wake_timer.sv
module idle_wake_timer #(
  parameter int TAP_LSB  = 12,
  parameter int NUM_TAPS = 5,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_wdata,
  output logic [SEL_W-1:0] reg_rdata,
  output logic             irq_o,
  output logic             wake_o
);
  localparam int CNT_W    = TAP_LSB + NUM_TAPS;
  localparam int MAX_CODE = NUM_TAPS - 1;

  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] sel_q;
  logic             en_q, pend_q;

  always_ff @(posedge clk)
    if (cyc_en) cnt <= cnt + 1'b1;

  logic [CNT_W-1:0]    flips;
  logic [NUM_TAPS-1:0] taps;
  logic [SEL_W-1:0]    code;
  logic                tap_evt;

  assign flips   = cnt ^ (cnt + 1'b1);
  assign taps    = flips[CNT_W-1:TAP_LSB];
  assign code    = (sel_q > SEL_W'(MAX_CODE)) ? SEL_W'(MAX_CODE) : sel_q;
  assign tap_evt = cyc_en & taps[code];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      wake_o <= tap_evt;
      if (reg_wr && !reg_addr) sel_q <= reg_wdata;
      if (reg_wr && reg_addr)  en_q  <= reg_wdata[0];
      if (tap_evt)
        pend_q <= 1'b1;
      else if (reg_wr && reg_addr && !reg_wdata[1])
        pend_q <= 1'b0;
    end
  end

  assign reg_rdata = reg_addr ? {{(SEL_W-2){1'b0}}, pend_q, en_q} : sel_q;
  assign irq_o     = pend_q & en_q;

  assert_wake_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  assert_wake_sets_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> pend_q);

  assert_strobe_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> !wake_o);

  assert_clear_vs_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && !reg_wdata[1]) |=> (pend_q == wake_o));

  assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && !reg_addr) |=> $stable(sel_q));
endmodule

// File: tb/test_idle_wake_timer.sv
module test_idle_wake_timer;
  localparam int LSB = 6;
  localparam int P0  = 1 << LSB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b1;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_wdata = '0;
  logic [2:0] reg_rdata;
  logic       irq_o, wake_o;

  idle_wake_timer #(.TAP_LSB(LSB), .NUM_TAPS(5), .SEL_W(3)) i_idle_wake_timer (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .wake_o(wake_o));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, last = 0, nwake = 0, first_wake = 0;
  bit mute = 1'b1, half = 1'b0, done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    cyc_en = half ? ~cyc_en : 1'b1;
  end

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      cyc++;
      if (wake_o) begin
        if (nwake == 0) first_wake = cyc;
        if (!mute && exp_q.size() > 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cyc - last == e, t, cyc - last, e);
        end
        last = cyc;
        nwake++;
      end
    end
  end

  task automatic wr(input logic a, input logic [2:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_wake();
    int n;
    n = nwake;
    while (nwake == n) @(negedge clk);
  endtask

  task automatic run_period(input logic [2:0] code, input bit hr, input int exp, input string t);
    mute = 1'b1;
    wr(1'b0, code);
    half = hr;
    @(negedge clk);
    @(negedge clk);
    wait_wake();
    mute = 1'b0;
    repeat (2) begin exp_q.push_back(exp); tag_q.push_back(t); end
    while (exp_q.size() > 0) @(negedge clk);
    mute = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reg_addr = 1'b0;
    check(reg_rdata == 3'd0, "R2 sel reset", reg_rdata, 0);
    reg_addr = 1'b1;
    check(reg_rdata == 3'd0, "R2 ctl reset", reg_rdata, 0);
    check({irq_o, wake_o} == 2'b00, "R2 outputs reset", {irq_o, wake_o}, 0);
    rst_n = 1'b1;
    wait_wake();
    check(first_wake >= 1 && first_wake <= P0, "R2 first wake", first_wake, P0);

    reg_addr = 1'b1;
    #1;
    check(reg_rdata == 3'b010, "R5 pending after wake", reg_rdata, 2);
    check(irq_o == 1'b0, "R6 irq masked", irq_o, 0);
    wr(1'b1, 3'b011);
    check(reg_rdata == 3'b011, "R7 write one keeps pend", reg_rdata, 3);
    check(irq_o == 1'b1, "R6 irq enabled", irq_o, 1);
    wr(1'b1, 3'b001);
    check(reg_rdata == 3'b001, "R7 clear pend", reg_rdata, 1);
    check(irq_o == 1'b0, "R6 irq after clear", irq_o, 0);
    reg_addr = 1'b0;
    #1;
    check(reg_rdata == 3'd0, "R8 ctl write leaves sel", reg_rdata, 0);

    wait_wake();
    repeat (63) @(negedge clk);
    wr(1'b1, 3'b001);
    check(wake_o == 1'b1, "R5 wake on event edge", wake_o, 1);
    check(reg_rdata == 3'b011, "R7 event beats clear", reg_rdata, 3);

    run_period(3'd0, 1'b0, P0,      "R1 code0");
    run_period(3'd1, 1'b0, P0 * 2,  "R1 code1");
    run_period(3'd2, 1'b0, P0 * 4,  "R1 code2");
    run_period(3'd3, 1'b0, P0 * 8,  "R1 code3");
    run_period(3'd4, 1'b0, P0 * 16, "R1 code4");
    run_period(3'd7, 1'b0, P0 * 16, "R3 code7");
    run_period(3'd5, 1'b0, P0 * 16, "R3 code5");
    reg_addr = 1'b0;
    #1;
    check(reg_rdata == 3'd5, "R8 sel readback", reg_rdata, 5);
    run_period(3'd1, 1'b1, P0 * 4,  "R4 half-rate strobe");
    half = 1'b0;
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 150000) begin
      @(negedge clk);
      n++;
    end
    if (!done) check(1'b0, "watchdog", n, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule